// File: doc/BRIEF.md
# Instruction Legality Checker for a Configurable Core

This block sits in the decode stage of a 32-bit core. The multiplier, divider, barrel shifter and sign extender of that core are each optional. Each cycle the block can accept one instruction word, together with its fetch PC and the value of the shift-amount register operand. It returns a verdict for that instruction. The verdict is one of four outcomes: illegal-instruction, system-call request, break request, or a flag that marks a write to a read-only control register. The verdict comes with the PC that the core records when it halts on a fault.

A feature mask input describes which optional units are present. The mask is static: it changes only while the block holds no instruction. For right shifts on a core without a shifter, the block checks the instruction at run time. Such a shift stays legal only when its amount is exactly one. For the register form, the amount is taken from the operand value.

The block has two stream interfaces. Instructions enter through a valid/ready input. The verdict leaves through a valid/ready output held in a single register stage. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a full round of back-pressure costs no bubble. A result that is offered and not taken stays unchanged until `out_ready` rises. All opcode values, control-register indices and the system-call immediates are parameters.

Top module: `insn_legal_chk`

## Requirements
- R1: The opcode is `in_insn[31:26]` and the 5-bit immediate is `in_insn[4:0]`. Feature mask bits are: bit 0 multiplier, bit 1 divider, bit 2 shifter, bit 3 sign extender. A multiply in register form or in immediate form is flagged illegal exactly when bit 0 is clear.
- R2: Divide and modulo are flagged illegal exactly when mask bit 1 is clear.
- R3: Sign-extend-byte and sign-extend-halfword are flagged illegal exactly when mask bit 3 is clear.
- R4: Left shift, in register form and in immediate form, is flagged illegal exactly when mask bit 2 is clear.
- R5: Arithmetic and logical right shifts in immediate form are always legal when mask bit 2 is set. When bit 2 is clear, they are legal only if the immediate equals 1.
- R6: With mask bit 2 clear, the register forms of arithmetic and logical right shift are legal only if bits [4:0] of `in_shift_opnd` equal 1. Higher operand bits are ignored, so an operand of 33 is legal. With bit 2 set, these forms are always legal.
- R7: In the system-call opcode class, immediate 7 raises `out_syscall` and immediate 2 raises `out_break`. Any other immediate raises `out_illegal`. At most one of these three flags is high in any result.
- R8: The user-defined opcode is always flagged illegal, whatever the feature mask holds.
- R9: `out_pc` equals the fetch PC with bits [1:0] cleared. A misaligned PC alone never sets any flag.
- R10: For the control-register write opcode, the register index is `in_insn[25:21]`. A write to the cycle-counter index (5'h0B) or to the configuration index (5'h06) sets `out_csr_bad` and no trap flag. A write to any other index sets no flag.
- R11: Every accepted input yields exactly one result, in order. A result offered while `out_ready` is low stays valid and unchanged. `in_ready` is high when the output register is empty or `out_ready` is high.
- R12: After reset `out_valid` is low and `in_ready` is high.
- R13: Every opcode outside the listed classes produces a result with all four flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_mask | input | 4 | Present optional units (multiply, divide, shift, sign extend) |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_insn | input | 32 | Instruction word |
| in_pc | input | 32 | Fetch PC of the instruction |
| in_shift_opnd | input | 32 | Shift-amount register value for register-form shifts |
| out_valid | output | 1 | Verdict offered |
| out_ready | input | 1 | Consumer takes the verdict |
| out_illegal | output | 1 | Instruction is illegal; core halts |
| out_syscall | output | 1 | System-call exception request |
| out_break | output | 1 | Break exception request |
| out_csr_bad | output | 1 | Ignored write to a read-only control register |
| out_pc | output | 32 | Word-aligned PC to record |

## Verification
The bench builds the block with its default opcode, register-index and immediate parameters, and passes each one explicitly from its own constants. The feature mask is a port, so one build can reach every combination of units. The bench runs fully equipped, fully stripped and single-unit configurations, plus randomly masked blocks. This covers the run-time shift-amount check, including operands whose high bits must be ignored. The consumer runs in a steady mode and in a randomly stalling mode, so results are checked both when they flow straight through and when they are held.

// File: rtl/ilc_pkg.sv
package ilc_pkg;
  localparam int FEAT_W = 4;
  localparam int F_MUL  = 0;
  localparam int F_DIV  = 1;
  localparam int F_SHF  = 2;
  localparam int F_SXT  = 3;

  // Instruction classes seen by the legality logic
  typedef enum logic [3:0] {
    K_PLAIN,
    K_MUL,
    K_DIV,
    K_SEXT,
    K_SHL,
    K_SHR_IMM,
    K_SHR_REG,
    K_SYS,
    K_USER,
    K_WCSR
  } kind_e;

  typedef struct packed {
    logic illegal;
    logic syscall;
    logic brk;
    logic csr_bad;
  } verdict_t;

  localparam int VERDICT_W = $bits(verdict_t);
endpackage

// File: rtl/ilc_classify.sv
module ilc_classify
  import ilc_pkg::*;
#(
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] OPC_MUL_R  = 6'h22,
  parameter logic [OPC_W-1:0] OPC_MUL_I  = 6'h02,
  parameter logic [OPC_W-1:0] OPC_DIV    = 6'h23,
  parameter logic [OPC_W-1:0] OPC_MOD    = 6'h31,
  parameter logic [OPC_W-1:0] OPC_SXB    = 6'h2C,
  parameter logic [OPC_W-1:0] OPC_SXH    = 6'h37,
  parameter logic [OPC_W-1:0] OPC_SL_R   = 6'h2F,
  parameter logic [OPC_W-1:0] OPC_SL_I   = 6'h0F,
  parameter logic [OPC_W-1:0] OPC_SR_R   = 6'h25,
  parameter logic [OPC_W-1:0] OPC_SR_I   = 6'h05,
  parameter logic [OPC_W-1:0] OPC_SRU_R  = 6'h20,
  parameter logic [OPC_W-1:0] OPC_SRU_I  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_SYS    = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_USER   = 6'h33,
  parameter logic [OPC_W-1:0] OPC_WCSR   = 6'h34
) (
  input  logic [OPC_W-1:0] opc,
  output kind_e            kind
);

  always_comb begin
    kind = K_PLAIN;
    if (opc == OPC_MUL_R || opc == OPC_MUL_I)      kind = K_MUL;
    else if (opc == OPC_DIV || opc == OPC_MOD)     kind = K_DIV;
    else if (opc == OPC_SXB || opc == OPC_SXH)     kind = K_SEXT;
    else if (opc == OPC_SL_R || opc == OPC_SL_I)   kind = K_SHL;
    else if (opc == OPC_SR_I || opc == OPC_SRU_I)  kind = K_SHR_IMM;
    else if (opc == OPC_SR_R || opc == OPC_SRU_R)  kind = K_SHR_REG;
    else if (opc == OPC_SYS)                       kind = K_SYS;
    else if (opc == OPC_USER)                      kind = K_USER;
    else if (opc == OPC_WCSR)                      kind = K_WCSR;
  end

endmodule

// File: rtl/ilc_judge.sv
module ilc_judge
  import ilc_pkg::*;
#(
  parameter int IMM_W = 5,
  parameter int CSR_W = 5,
  parameter logic [CSR_W-1:0] CSR_CYCLE = 5'h0B,
  parameter logic [CSR_W-1:0] CSR_CONF  = 5'h06,
  parameter logic [IMM_W-1:0] IMM_SCALL = 5'd7,
  parameter logic [IMM_W-1:0] IMM_BREAK = 5'd2
) (
  input  kind_e               kind,
  input  logic [FEAT_W-1:0]   feat,
  input  logic [IMM_W-1:0]    imm,
  input  logic [IMM_W-1:0]    sh_amt,
  input  logic [CSR_W-1:0]    csr_idx,
  output verdict_t            verdict
);

  localparam logic [IMM_W-1:0] ONE = IMM_W'(1);

  logic imm_is_one, amt_is_one, no_shifter;

  assign imm_is_one = (imm == ONE);
  assign amt_is_one = (sh_amt == ONE);
  assign no_shifter = !feat[F_SHF];

  always_comb begin
    verdict = '0;
    unique case (kind)
      K_MUL:     verdict.illegal = !feat[F_MUL];
      K_DIV:     verdict.illegal = !feat[F_DIV];
      K_SEXT:    verdict.illegal = !feat[F_SXT];
      K_SHL:     verdict.illegal = no_shifter;
      K_SHR_IMM: verdict.illegal = no_shifter && !imm_is_one;
      K_SHR_REG: verdict.illegal = no_shifter && !amt_is_one;
      K_SYS: begin
        // trap beats request: an unknown immediate never raises one
        if (imm == IMM_SCALL)      verdict.syscall = 1'b1;
        else if (imm == IMM_BREAK) verdict.brk     = 1'b1;
        else                       verdict.illegal = 1'b1;
      end
      K_USER:    verdict.illegal = 1'b1;
      K_WCSR:    verdict.csr_bad = (csr_idx == CSR_CYCLE) || (csr_idx == CSR_CONF);
      default:   verdict = '0;
    endcase
  end

endmodule

// File: rtl/ilc_pc_align.sv
module ilc_pc_align #(
  parameter int AW       = 32,
  parameter int LOW_BITS = 2
) (
  input  logic [AW-1:0] pc_in,
  output logic [AW-1:0] pc_out
);

  for (genvar b = 0; b < AW; b++) begin : g_bit
    if (b < LOW_BITS) begin : g_clear
      assign pc_out[b] = 1'b0;
    end else begin : g_keep
      assign pc_out[b] = pc_in[b];
    end
  end

endmodule

// File: rtl/ilc_stage.sv
module ilc_stage #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end

endmodule

// File: rtl/insn_legal_chk.sv
module insn_legal_chk
  import ilc_pkg::*;
#(
  parameter int IW    = 32,
  parameter int AW    = 32,
  parameter int OPC_W = 6,
  parameter int IMM_W = 5,
  parameter int CSR_W = 5,
  parameter int CSR_LSB = 21,
  parameter int PC_LOW_BITS = 2,
  parameter logic [OPC_W-1:0] OPC_MUL_R  = 6'h22,
  parameter logic [OPC_W-1:0] OPC_MUL_I  = 6'h02,
  parameter logic [OPC_W-1:0] OPC_DIV    = 6'h23,
  parameter logic [OPC_W-1:0] OPC_MOD    = 6'h31,
  parameter logic [OPC_W-1:0] OPC_SXB    = 6'h2C,
  parameter logic [OPC_W-1:0] OPC_SXH    = 6'h37,
  parameter logic [OPC_W-1:0] OPC_SL_R   = 6'h2F,
  parameter logic [OPC_W-1:0] OPC_SL_I   = 6'h0F,
  parameter logic [OPC_W-1:0] OPC_SR_R   = 6'h25,
  parameter logic [OPC_W-1:0] OPC_SR_I   = 6'h05,
  parameter logic [OPC_W-1:0] OPC_SRU_R  = 6'h20,
  parameter logic [OPC_W-1:0] OPC_SRU_I  = 6'h00,
  parameter logic [OPC_W-1:0] OPC_SYS    = 6'h2B,
  parameter logic [OPC_W-1:0] OPC_USER   = 6'h33,
  parameter logic [OPC_W-1:0] OPC_WCSR   = 6'h34,
  parameter logic [CSR_W-1:0] CSR_CYCLE  = 5'h0B,
  parameter logic [CSR_W-1:0] CSR_CONF   = 5'h06,
  parameter logic [IMM_W-1:0] IMM_SCALL  = 5'd7,
  parameter logic [IMM_W-1:0] IMM_BREAK  = 5'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        feat_mask,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IW-1:0]     in_insn,
  input  logic [AW-1:0]     in_pc,
  input  logic [IW-1:0]     in_shift_opnd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_illegal,
  output logic              out_syscall,
  output logic              out_break,
  output logic              out_csr_bad,
  output logic [AW-1:0]     out_pc
);

  localparam int OPC_LSB = IW - OPC_W;
  localparam int DATA_W  = VERDICT_W + AW;

  kind_e        kind;
  verdict_t     verdict;
  verdict_t     verdict_q;
  logic [AW-1:0] pc_aligned;
  logic [DATA_W-1:0] stage_in, stage_out;

  ilc_classify #(
    .OPC_W(OPC_W),
    .OPC_MUL_R(OPC_MUL_R), .OPC_MUL_I(OPC_MUL_I),
    .OPC_DIV(OPC_DIV),     .OPC_MOD(OPC_MOD),
    .OPC_SXB(OPC_SXB),     .OPC_SXH(OPC_SXH),
    .OPC_SL_R(OPC_SL_R),   .OPC_SL_I(OPC_SL_I),
    .OPC_SR_R(OPC_SR_R),   .OPC_SR_I(OPC_SR_I),
    .OPC_SRU_R(OPC_SRU_R), .OPC_SRU_I(OPC_SRU_I),
    .OPC_SYS(OPC_SYS),     .OPC_USER(OPC_USER),
    .OPC_WCSR(OPC_WCSR)
  ) u_classify (
    .opc  (in_insn[IW-1:OPC_LSB]),
    .kind (kind)
  );

  ilc_judge #(
    .IMM_W(IMM_W), .CSR_W(CSR_W),
    .CSR_CYCLE(CSR_CYCLE), .CSR_CONF(CSR_CONF),
    .IMM_SCALL(IMM_SCALL), .IMM_BREAK(IMM_BREAK)
  ) u_judge (
    .kind    (kind),
    .feat    (feat_mask),
    .imm     (in_insn[IMM_W-1:0]),
    .sh_amt  (in_shift_opnd[IMM_W-1:0]),
    .csr_idx (in_insn[CSR_LSB+CSR_W-1:CSR_LSB]),
    .verdict (verdict)
  );

  ilc_pc_align #(.AW(AW), .LOW_BITS(PC_LOW_BITS)) u_align (
    .pc_in  (in_pc),
    .pc_out (pc_aligned)
  );

  assign stage_in = {verdict, pc_aligned};

  ilc_stage #(.W(DATA_W)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (in_valid),
    .s_ready (in_ready),
    .s_data  (stage_in),
    .m_valid (out_valid),
    .m_ready (out_ready),
    .m_data  (stage_out)
  );

  assign verdict_q   = stage_out[DATA_W-1:AW];
  assign out_pc      = stage_out[AW-1:0];
  assign out_illegal = verdict_q.illegal;
  assign out_syscall = verdict_q.syscall;
  assign out_break   = verdict_q.brk;
  assign out_csr_bad = verdict_q.csr_bad;

endmodule

// File: rtl/ilc_assert.sv
module ilc_assert #(
  parameter int IW = 32,
  parameter int AW = 32,
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] OPC_USER = 6'h33
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [IW-1:0] in_insn,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_illegal,
  input logic          out_syscall,
  input logic          out_break,
  input logic          out_csr_bad,
  input logic [AW-1:0] out_pc
);

  a_r7_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0({out_illegal, out_syscall, out_break}));

  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_pc[1:0] == 2'b00));

  a_r11_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_illegal, out_syscall, out_break, out_csr_bad, out_pc})));

  a_r11_accept_yields: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r8_user_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_insn[IW-1:IW-OPC_W] == OPC_USER) |=> out_illegal);

  a_r10_csr_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_csr_bad) |-> !(out_illegal || out_syscall || out_break));

endmodule

bind insn_legal_chk ilc_assert #(
  .IW(IW), .AW(AW), .OPC_W(OPC_W), .OPC_USER(OPC_USER)
) u_ilc_assert (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_insn(in_insn), .out_valid(out_valid), .out_ready(out_ready),
  .out_illegal(out_illegal), .out_syscall(out_syscall), .out_break(out_break),
  .out_csr_bad(out_csr_bad), .out_pc(out_pc)
);

// File: tb/insn_legal_chk_test.sv
module insn_legal_chk_test;
  localparam int CLK_PERIOD = 10;

  localparam logic [5:0] O_MULR = 6'h22, O_MULI = 6'h02, O_DIV = 6'h23, O_MOD = 6'h31;
  localparam logic [5:0] O_SXB = 6'h2C, O_SXH = 6'h37, O_SLR = 6'h2F, O_SLI = 6'h0F;
  localparam logic [5:0] O_SRR = 6'h25, O_SRI = 6'h05, O_SRUR = 6'h20, O_SRUI = 6'h00;
  localparam logic [5:0] O_SYS = 6'h2B, O_USR = 6'h33, O_WCSR = 6'h34, O_ADD = 6'h0D;
  localparam logic [4:0] C_CYC = 5'h0B, C_CFG = 5'h06;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  feat_mask = 4'hF;
  logic        in_valid = 0, in_ready;
  logic [31:0] in_insn = 0, in_pc = 0, in_shift_opnd = 0;
  logic        out_valid, out_ready = 1;
  logic        out_illegal, out_syscall, out_break, out_csr_bad;
  logic [31:0] out_pc;

  int checks = 0, fails = 0;
  int stall_mode = 0;
  logic [35:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_legal_chk #(
    .OPC_MUL_R(O_MULR), .OPC_MUL_I(O_MULI), .OPC_DIV(O_DIV), .OPC_MOD(O_MOD),
    .OPC_SXB(O_SXB), .OPC_SXH(O_SXH), .OPC_SL_R(O_SLR), .OPC_SL_I(O_SLI),
    .OPC_SR_R(O_SRR), .OPC_SR_I(O_SRI), .OPC_SRU_R(O_SRUR), .OPC_SRU_I(O_SRUI),
    .OPC_SYS(O_SYS), .OPC_USER(O_USR), .OPC_WCSR(O_WCSR),
    .CSR_CYCLE(C_CYC), .CSR_CONF(C_CFG), .IMM_SCALL(5'd7), .IMM_BREAK(5'd2)
  ) uut (.*);

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] csr, input logic [4:0] imm);
    return {op, csr, 16'h0, imm};
  endfunction

  // Expected flags {illegal, syscall, break, csr_bad} derived from the requirements
  function automatic logic [3:0] model(input logic [3:0] f, input logic [31:0] w, input logic [31:0] sh);
    logic [5:0] op = w[31:26];
    logic [4:0] imm = w[4:0];
    logic [4:0] csr = w[25:21];
    logic il = 0, sc = 0, bk = 0, cb = 0;
    if (op == O_MULR || op == O_MULI)      il = !f[0];
    else if (op == O_DIV || op == O_MOD)   il = !f[1];
    else if (op == O_SXB || op == O_SXH)   il = !f[3];
    else if (op == O_SLR || op == O_SLI)   il = !f[2];
    else if (op == O_SRI || op == O_SRUI)  il = !f[2] && imm != 5'd1;
    else if (op == O_SRR || op == O_SRUR)  il = !f[2] && sh[4:0] != 5'd1;
    else if (op == O_SYS) begin
      if (imm == 5'd7) sc = 1; else if (imm == 5'd2) bk = 1; else il = 1;
    end
    else if (op == O_USR)  il = 1;
    else if (op == O_WCSR) cb = (csr == C_CYC) || (csr == C_CFG);
    return {il, sc, bk, cb};
  endfunction

  function automatic string tag_of(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    if (op == O_MULR || op == O_MULI) return "R1";
    if (op == O_DIV || op == O_MOD)   return "R2";
    if (op == O_SXB || op == O_SXH)   return "R3";
    if (op == O_SLR || op == O_SLI)   return "R4";
    if (op == O_SRI || op == O_SRUI)  return "R5";
    if (op == O_SRR || op == O_SRUR)  return "R6";
    if (op == O_SYS)  return "R7";
    if (op == O_USR)  return "R8";
    if (op == O_WCSR) return "R10";
    return "R13";
  endfunction

  function automatic logic [5:0] pick(input int k);
    case (k % 16)
      0: return O_MULR;  1: return O_MULI;  2: return O_DIV;  3: return O_MOD;
      4: return O_SXB;   5: return O_SXH;   6: return O_SLR;  7: return O_SLI;
      8: return O_SRR;   9: return O_SRI;  10: return O_SRUR; 11: return O_SRUI;
      12: return O_SYS; 13: return O_USR;  14: return O_WCSR; default: return O_ADD;
    endcase
  endfunction

  // Driver: offer one instruction, wait for acceptance, push its expectation (R11 order)
  task automatic send(input logic [31:0] w, input logic [31:0] pc, input logic [31:0] sh);
    @(negedge clk);
    in_valid = 1; in_insn = w; in_pc = pc; in_shift_opnd = sh;
    while (!in_ready) @(negedge clk);
    exp_q.push_back({model(feat_mask, w, sh), pc & 32'hFFFF_FFFC});
    tag_q.push_back(tag_of(w));
  endtask

  task automatic idle_and_drain();
    @(negedge clk);
    in_valid = 0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Consumer ready pattern, updated just after each rising edge
  always @(posedge clk) begin
    #1;
    if (stall_mode == 0) out_ready = 1;
    else out_ready = ($urandom % 3) != 0;
  end

  // Monitor: a transfer happens at the next edge when both are high (R11)
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected result", 64'(out_valid), 64'(0));
      end else begin
        logic [35:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {28'h0, out_illegal, out_syscall, out_break, out_csr_bad, out_pc}, 64'(e));
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 out_valid", 64'(out_valid), 64'(0));
    check("R12 in_ready", 64'(in_ready), 64'(1));
    rst_n = 1;

    // Full feature set
    feat_mask = 4'hF;
    send(mk(O_MULR, 0, 0), 32'h100, 0);
    send(mk(O_MULI, 0, 9), 32'h104, 0);
    send(mk(O_DIV, 0, 0), 32'h108, 0);
    send(mk(O_MOD, 0, 0), 32'h10C, 0);
    send(mk(O_SXB, 0, 0), 32'h110, 0);
    send(mk(O_SXH, 0, 0), 32'h114, 0);
    send(mk(O_SLI, 0, 4), 32'h118, 0);
    send(mk(O_SRI, 0, 5), 32'h11C, 0);
    send(mk(O_SRR, 0, 0), 32'h120, 32'd7);
    send(mk(O_SYS, 0, 7), 32'h124, 0);   // R7 syscall
    send(mk(O_SYS, 0, 2), 32'h128, 0);   // R7 break
    send(mk(O_SYS, 0, 3), 32'h12C, 0);   // R7 unknown -> illegal
    send(mk(O_USR, 0, 0), 32'h130, 0);   // R8
    send(mk(O_WCSR, C_CYC, 0), 32'h134, 0); // R10
    send(mk(O_WCSR, C_CFG, 0), 32'h138, 0); // R10
    send(mk(O_WCSR, 5'h03, 0), 32'h13C, 0); // R10 other index
    send(mk(O_ADD, 0, 0), 32'h143, 0);   // R9 misaligned, R13 plain
    idle_and_drain();

    // Nothing present, consumer stalls at random
    stall_mode = 1;
    feat_mask = 4'h0;
    send(mk(O_MULR, 0, 0), 32'h200, 0);
    send(mk(O_MULI, 0, 1), 32'h205, 0);
    send(mk(O_DIV, 0, 0), 32'h20A, 0);
    send(mk(O_SXH, 0, 0), 32'h20C, 0);
    send(mk(O_SLR, 0, 0), 32'h210, 32'd1);   // R4 register form
    send(mk(O_SLI, 0, 1), 32'h214, 0);       // R4 immediate form
    send(mk(O_SRI, 0, 1), 32'h218, 0);       // R5 legal
    send(mk(O_SRUI, 0, 1), 32'h21C, 0);      // R5 legal
    send(mk(O_SRI, 0, 0), 32'h220, 0);       // R5 illegal
    send(mk(O_SRUI, 0, 3), 32'h224, 0);      // R5 illegal
    send(mk(O_SRR, 0, 0), 32'h228, 32'd33);  // R6 high bits ignored -> legal
    send(mk(O_SRR, 0, 0), 32'h22C, 32'd2);   // R6 illegal
    send(mk(O_SRUR, 0, 0), 32'h230, 32'd1);  // R6 legal
    send(mk(O_SRUR, 0, 1), 32'h234, 32'd0);  // R6 illegal, imm field ignored
    send(mk(O_USR, 0, 0), 32'h237, 0);       // R8
    send(mk(O_SYS, 0, 7), 32'h23B, 0);       // R7
    idle_and_drain();

    // Multiplier only
    feat_mask = 4'b0001;
    send(mk(O_MULR, 0, 0), 32'h300, 0);
    send(mk(O_MOD, 0, 0), 32'h304, 0);
    send(mk(O_SXB, 0, 0), 32'h308, 0);
    // Shifter only
    idle_and_drain();
    feat_mask = 4'b0100;
    send(mk(O_SRR, 0, 0), 32'h400, 32'd6);
    send(mk(O_SLR, 0, 0), 32'h404, 32'd6);
    send(mk(O_MULI, 0, 0), 32'h408, 0);
    idle_and_drain();

    // Randomized blocks
    for (int blk = 0; blk < 8; blk++) begin
      feat_mask = 4'($urandom);
      for (int n = 0; n < 40; n++) begin
        send(mk(pick($urandom), 5'($urandom), 5'($urandom % 9)),
             $urandom, ($urandom % 3 == 0) ? 32'($urandom % 70) : 32'd1);
      end
      idle_and_drain();
    end

    check("R11 queue drained", 64'(exp_q.size()), 64'(0));
    finish_run();
  end

endmodule